// File: doc/BRIEF.md
# Charge Pump Fastlock Timer Controller

This block decides which of two charge-pump current codes reaches the pump driver. One code is the steady code, used while the loop is settled. The other is the fast code, used to speed up acquisition after a frequency change. The choice follows a gain flag. Software writes the flag each time it loads the feedback divider, and the flag can be read back at any time.

When fastlock is enabled in its timed mode, a write of 1 to the gain flag also starts a timer. The timer counts phase-detector cycles, reported as one-cycle `pd_tick` pulses. When the programmed number of cycles has passed, the gain flag clears itself and the output falls back to the steady code. The timeout is set by a 4-bit code and grows in steps of four cycles.

The block also requests a high-impedance pump output. It does so whenever the pump-disable setting, a power-down or a divider counter reset is present. Turning the code into an analog current is done outside this block.

Top module: `cpfl_ctrl`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), `gain_flag` is 0 and `icp_code` equals `cur_steady`.
- R2: `icp_code` equals `cur_fast` while `gain_flag` is 1 and equals `cur_steady` while it is 0, in every mode.
- R3: A cycle with `gain_wr` high loads `gain_din` into `gain_flag` at that clock edge. Without a write, `gain_flag` changes only through R5.
- R4: With `fl_en`=1 and `fl_mode`=0 (manual fastlock), `gain_flag`=1 holds through any number of `pd_tick` pulses.
- R5: With `fl_en`=1 and `fl_mode`=1 (timed fastlock), `gain_flag` clears at the clock edge that samples the N-th `pd_tick` after the write of 1. Here N = 3 + 4 × `tmo_code` (3 for code 0, 63 for code 15). A tick in the same cycle as the write is not counted.
- R6: In timed fastlock, a further write of 1 while the timer runs restarts the count, so N more ticks are then needed.
- R7: With `fl_en`=0, `gain_flag` never clears by itself, whatever `fl_mode` and `pd_tick` do.
- R8: `cp_hiz` is 1 exactly when at least one of `cp_off`, `pwr_down` or `cnt_reset` is 1.
- R9: While `pwr_down` is 1, the timer is held at its load state and ticks are not counted. After release, a full N ticks are needed; `gain_flag` is kept through the power-down.
- R10: A gain write in the same cycle as an expiring tick takes priority. Writing 1 there keeps the flag at 1 and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_steady | input | CODE_W | Steady current code |
| cur_fast | input | CODE_W | Fast-acquisition current code |
| fl_en | input | 1 | Fastlock enable |
| fl_mode | input | 1 | 0 manual fastlock, 1 timed fastlock |
| tmo_code | input | TMO_W | Timeout selection code |
| gain_wr | input | 1 | Strobe: divider load carrying a gain flag |
| gain_din | input | 1 | Gain flag value carried by the divider load |
| pd_tick | input | 1 | One pulse per phase-detector cycle |
| cp_off | input | 1 | Pump-disable setting |
| pwr_down | input | 1 | Any power-down condition |
| cnt_reset | input | 1 | Divider counters held in reset |
| icp_code | output | CODE_W | Active current code |
| cp_hiz | output | 1 | High-impedance request for the pump |
| gain_flag | output | 1 | Present gain flag |

## Verification
The bench uses the default parameters: 3-bit current codes, a 4-bit timeout code, a base of 3 cycles and a step of 4. Timeouts therefore run from 3 to 63 ticks, so the shortest and longest codes can both be walked tick by tick in a short run. At that length, restart, power-down hold and write-versus-expiry collisions can be placed at exact tick positions. A behavioural model tracks the flag and the elapsed ticks and is compared with the outputs on every cycle. Directed checks confirm the exact expiry edge for several codes.

// File: rtl/cpfl_pkg.sv
// Shared definitions for the charge pump fastlock controller.
// Assumes timeout lengths follow base + step * code.
package cpfl_pkg;

    // Fastlock operating state derived from the enable and mode inputs
    typedef enum logic [1:0] {
        FL_OFF    = 2'd0,
        FL_MANUAL = 2'd1,
        FL_TIMED  = 2'd2
    } fl_state_e;

    // Timeout length in phase-detector cycles for a given code
    function automatic int unsigned tmo_cycles(input int unsigned code,
                                               input int unsigned base,
                                               input int unsigned step);
        return base + step * code;
    endfunction

endpackage

// File: rtl/cpfl_tmo_lut.sv
// Maps the timeout code to a tick count through a table built at elaboration.
// Assumes CNT_W is wide enough for the largest entry.
module cpfl_tmo_lut #(
    parameter int TMO_W    = 4,
    parameter int TMO_BASE = 3,
    parameter int TMO_STEP = 4,
    parameter int CNT_W    = 6
) (
    input  logic [TMO_W-1:0] code,
    output logic [CNT_W-1:0] limit
);
    import cpfl_pkg::*;

    localparam int ENTRIES = 1 << TMO_W;

    logic [CNT_W-1:0] table_q [ENTRIES];

    // One constant entry per code
    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        assign table_q[i] = CNT_W'(tmo_cycles(i, TMO_BASE, TMO_STEP));
    end

    // Index the table with the present code
    assign limit = table_q[code];

endmodule

// File: rtl/cpfl_gain_timer.sv
// Holds the gain flag and the timed-fastlock tick counter.
// A write always wins; power-down or leaving timed mode returns the counter
// to zero (its load state). Assumes pd_tick lasts one clock per cycle.
module cpfl_gain_timer #(
    parameter int CNT_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  cpfl_pkg::fl_state_e  fl_state,
    input  logic [CNT_W-1:0]     limit,
    input  logic                 gain_wr,
    input  logic                 gain_din,
    input  logic                 pd_tick,
    input  logic                 pwr_down,
    output logic                 gain_q
);
    import cpfl_pkg::*;

    logic [CNT_W-1:0] elapsed_q;
    logic             armed;
    logic             expire;

    // Timer runs only in timed mode with the flag set and power applied
    assign armed  = (fl_state == FL_TIMED) && gain_q && !pwr_down;
    assign expire = armed && pd_tick && ((elapsed_q + 1'b1) == limit);

    // Gain flag: write first, then automatic clear on expiry
    always_ff @(posedge clk) begin
        if (!rst_n)       gain_q <= 1'b0;
        else if (gain_wr) gain_q <= gain_din;
        else if (expire)  gain_q <= 1'b0;
    end

    // Elapsed tick counter with restart and load-state hold
    always_ff @(posedge clk) begin
        if (!rst_n)                 elapsed_q <= '0;
        else if (gain_wr)           elapsed_q <= '0;
        else if (!armed || expire)  elapsed_q <= '0;
        else if (pd_tick)           elapsed_q <= elapsed_q + 1'b1;
    end

endmodule

// File: rtl/cpfl_drive.sv
// Chooses the active current code and forms the high-impedance request.
// Purely combinational; assumes the gain flag is already registered.
module cpfl_drive #(
    parameter int CODE_W = 3
) (
    input  logic              gain_q,
    input  logic [CODE_W-1:0] cur_steady,
    input  logic [CODE_W-1:0] cur_fast,
    input  logic              cp_off,
    input  logic              pwr_down,
    input  logic              cnt_reset,
    output logic [CODE_W-1:0] icp_code,
    output logic              cp_hiz
);
    // Code selection and high-impedance request
    always_comb begin
        icp_code = gain_q ? cur_fast : cur_steady;
        cp_hiz   = cp_off | pwr_down | cnt_reset;
    end

endmodule

// File: rtl/cpfl_ctrl.sv
// Top of the charge pump fastlock controller: decodes the fastlock mode,
// looks up the timeout and connects the timer and output stages.
// Assumes all inputs are synchronous to clk.
module cpfl_ctrl #(
    parameter int CODE_W   = 3,
    parameter int TMO_W    = 4,
    parameter int TMO_BASE = 3,
    parameter int TMO_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] cur_steady,
    input  logic [CODE_W-1:0] cur_fast,
    input  logic              fl_en,
    input  logic              fl_mode,
    input  logic [TMO_W-1:0]  tmo_code,
    input  logic              gain_wr,
    input  logic              gain_din,
    input  logic              pd_tick,
    input  logic              cp_off,
    input  logic              pwr_down,
    input  logic              cnt_reset,
    output logic [CODE_W-1:0] icp_code,
    output logic              cp_hiz,
    output logic              gain_flag
);
    import cpfl_pkg::*;

    localparam int MAX_TICKS = TMO_BASE + TMO_STEP * ((1 << TMO_W) - 1);
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    fl_state_e        fl_state;
    logic [CNT_W-1:0] limit;
    logic             gain_q;

    // Decode enable and mode into one fastlock state
    always_comb begin
        if (!fl_en)       fl_state = FL_OFF;
        else if (fl_mode) fl_state = FL_TIMED;
        else              fl_state = FL_MANUAL;
    end

    cpfl_tmo_lut #(
        .TMO_W(TMO_W), .TMO_BASE(TMO_BASE), .TMO_STEP(TMO_STEP), .CNT_W(CNT_W)
    ) u_lut (
        .code (tmo_code),
        .limit(limit)
    );

    cpfl_gain_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .fl_state(fl_state),
        .limit   (limit),
        .gain_wr (gain_wr),
        .gain_din(gain_din),
        .pd_tick (pd_tick),
        .pwr_down(pwr_down),
        .gain_q  (gain_q)
    );

    cpfl_drive #(.CODE_W(CODE_W)) u_drive (
        .gain_q    (gain_q),
        .cur_steady(cur_steady),
        .cur_fast  (cur_fast),
        .cp_off    (cp_off),
        .pwr_down  (pwr_down),
        .cnt_reset (cnt_reset),
        .icp_code  (icp_code),
        .cp_hiz    (cp_hiz)
    );

    assign gain_flag = gain_q;

endmodule

// File: rtl/cpfl_ctrl_chk.sv
// Property checker for cpfl_ctrl, attached by bind below.
module cpfl_ctrl_chk #(
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] cur_fast,
    input logic              fl_en,
    input logic              fl_mode,
    input logic              gain_wr,
    input logic              gain_din,
    input logic              pd_tick,
    input logic              pwr_down,
    input logic [CODE_W-1:0] icp_code,
    input logic              cp_hiz,
    input logic              gain_flag
);
    p_write_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gain_wr |=> gain_flag == $past(gain_din));

    p_no_self_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!gain_wr && !(fl_en && fl_mode)) |=> $stable(gain_flag));

    p_clear_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gain_flag) && !$past(gain_wr)) |->
            $past(fl_en && fl_mode && pd_tick && !pwr_down));

    p_pd_holds_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && !gain_wr) |=> $stable(gain_flag));

    p_fast_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gain_flag) |-> icp_code == cur_fast);

    p_pd_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> cp_hiz);

endmodule

bind cpfl_ctrl cpfl_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_fast (cur_fast),
    .fl_en    (fl_en),
    .fl_mode  (fl_mode),
    .gain_wr  (gain_wr),
    .gain_din (gain_din),
    .pd_tick  (pd_tick),
    .pwr_down (pwr_down),
    .icp_code (icp_code),
    .cp_hiz   (cp_hiz),
    .gain_flag(gain_flag)
);

// File: tb/sim_cpfl_ctrl.sv
module sim_cpfl_ctrl;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [2:0] cur_steady = 3'd2, cur_fast = 3'd6;
    logic       fl_en = 0, fl_mode = 0;
    logic [3:0] tmo_code = 0;
    logic       gain_wr = 0, gain_din = 0, pd_tick = 0;
    logic       cp_off = 0, pwr_down = 0, cnt_reset = 0;
    logic [2:0] icp_code;
    logic       cp_hiz, gain_flag;

    int checks = 0, errors = 0;
    int m_gain = 0, m_elapsed = 0;

    always #5 clk = ~clk;

    cpfl_ctrl u0 (.*);

    // Behavioural reference: flag and elapsed ticks
    always @(posedge clk) begin
        if (!rst_n) begin m_gain = 0; m_elapsed = 0; end
        else if (gain_wr) begin m_gain = gain_din; m_elapsed = 0; end
        else if (pwr_down || !(fl_en && fl_mode && m_gain == 1)) m_elapsed = 0;
        else if (pd_tick) begin
            if (m_elapsed + 1 == 3 + 4 * int'(tmo_code)) begin m_gain = 0; m_elapsed = 0; end
            else m_elapsed = m_elapsed + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the edge
    always @(negedge clk) if (rst_n) begin
        chk("R5 model flag", gain_flag, m_gain);
        chk("R2 model code", icp_code, (m_gain == 1) ? cur_fast : cur_steady);
        chk("R8 model hiz", cp_hiz, int'(cp_off | pwr_down | cnt_reset));
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic v);
        gain_wr = 1; gain_din = v; step(); gain_wr = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            pd_tick = 1; step(); pd_tick = 0; step();
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(); step(); step();
        chk("R1 flag", gain_flag, 0);
        chk("R1 code", icp_code, 2);
        rst_n = 1; step();

        // Fastlock disabled: flag permanent (R2, R7)
        wr(1);
        chk("R2 fast code", icp_code, 6);
        fl_mode = 1; ticks(70);
        chk("R7 no clear", gain_flag, 1);
        wr(0);
        chk("R3 write 0", gain_flag, 0);
        chk("R2 steady code", icp_code, 2);

        // Manual fastlock (R4)
        fl_en = 1; fl_mode = 0;
        wr(1); ticks(80);
        chk("R4 held", gain_flag, 1);
        wr(0);

        // Timed fastlock, codes 0, 15, 5 (R5)
        fl_mode = 1;
        tmo_code = 0; wr(1); ticks(2);
        chk("R5 code0 before", gain_flag, 1);
        ticks(1);
        chk("R5 code0 expiry", gain_flag, 0);
        tmo_code = 15; wr(1); ticks(62);
        chk("R5 code15 before", gain_flag, 1);
        ticks(1);
        chk("R5 code15 expiry", gain_flag, 0);
        tmo_code = 5; wr(1); ticks(22);
        chk("R5 code5 before", gain_flag, 1);
        ticks(1);
        chk("R5 code5 expiry", gain_flag, 0);

        // Restart (R6)
        tmo_code = 2; wr(1); ticks(8); wr(1); ticks(10);
        chk("R6 restarted", gain_flag, 1);
        ticks(1);
        chk("R6 expiry", gain_flag, 0);

        // Power-down hold (R9)
        tmo_code = 1; wr(1); ticks(5);
        pwr_down = 1; ticks(20);
        chk("R9 kept in pd", gain_flag, 1);
        pwr_down = 0; ticks(6);
        chk("R9 reloaded", gain_flag, 1);
        ticks(1);
        chk("R9 expiry", gain_flag, 0);

        // Write collides with expiring tick (R10)
        tmo_code = 0; wr(1); ticks(2);
        pd_tick = 1; wr(1); pd_tick = 0; step();
        chk("R10 write wins", gain_flag, 1);
        ticks(2);
        chk("R10 restarted", gain_flag, 1);
        ticks(1);
        chk("R10 expiry", gain_flag, 0);

        // High-impedance combinations (R8)
        for (int v = 0; v < 8; v++) begin
            {cp_off, pwr_down, cnt_reset} = 3'(v);
            step();
            chk("R8 hiz", cp_hiz, int'(v != 0));
        end
        {cp_off, pwr_down, cnt_reset} = 3'b000; step();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule